// File: doc/BRIEF.md
# Programmable Static Memory Bank Controller

This block is the host-side engine for one chip-select bank of an external asynchronous memory or peripheral bus. An internal master issues one single-beat read or write at a time through a valid/ready handshake. The block checks whether the address falls inside the bank window. A request inside the window is turned into chip-select, output-enable, write-enable, address and 16-bit data waveforms. Each phase of the resulting cycle has a length that is programmed separately.

The phase lengths come from a packed 15-bit timing word that holds nonlinear field codes. A width field chooses between a 16-bit half-word addressed bus and an 8-bit byte addressed bus. An optional wait input can stretch the access phase, but only when the programmed access time is long enough for the input to be sampled safely. Read data is captured as the strobe rises. Completion is signalled by a single-cycle done pulse after the address-hold phase.

Top module: `sram_bank_ctrl`

## Requirements
- R1: A request whose address lies in 0x2000_0000..0x27FF_FFFF runs an external cycle. Any other address is accepted and completes with a done pulse in the first cycle after acceptance, without asserting chip select and without changing the read data output.
- R2: The two setup fields and the two hold fields of the timing word each map the codes 00, 01, 10 and 11 to 0, 1, 2 and 4 clocks. The fields are: address-before-CS setup in bits [14:13], CS-before-strobe setup in [12:11], CS hold after the strobe in [7:6], and address hold after CS in [5:4].
- R3: The access field, bits [10:8], maps codes 000 through 111 to 1, 2, 3, 4, 6, 8, 10 and 14 clocks of strobe-low time.
- R4: After acceptance the phases run in this order: address valid with CS high; CS low with the strobe high; strobe low; CS low again with the strobe high; CS high with the address still held. A phase programmed to zero clocks is skipped.
- R5: A read pulses only output-enable and a write pulses only write-enable. During a write, the data output enable is high for every external phase and the write data is driven on the data bus.
- R6: Read data is taken from the data input on the clock edge at which the strobe deasserts. It is held on the read data output until the next read inside the window.
- R7: The done output is high for exactly one cycle, directly after the last external phase. Ready is high only while the block is idle, so a new request can be accepted in the cycle after done.
- R8: The wait input (high = stretch) is honoured only when wait is enabled and the access code is 011 or higher (at least 4 clocks). It is then sampled in the final access clock, and the strobe is extended one clock for each cycle in which it is high. In every other case it has no effect.
- R9: The timing word, width and wait enable are captured when a request is accepted. Changing them during a cycle does not alter that cycle.
- R10: Width code 01 (and 1x) selects a 16-bit bus: the external address is request address bits [26:1], and all 16 data bits are used. Code 00 selects an 8-bit bus: the external address is request address bits [25:0], the upper write byte is driven as zero, and the upper read byte is returned as zero.
- R11: The page-time field [3:2] and the page-configuration field [1:0] have no effect, since only normal single-data access is provided.
- R12: Timing word 0x5CEC gives phases of 2, 4, 6, 4 and 2 clocks. Timing word 0x3294 gives 1, 2, 3, 2 and 1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last captured read data |
| cfg_timing | input | 15 | Packed bank timing word |
| cfg_width | input | 2 | Bus width code |
| cfg_wait_en | input | 1 | Allow the wait input to stretch access |
| ext_cs_n | output | 1 | Bank chip select, active low |
| ext_oe_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_addr | output | 26 | External address |
| ext_data_out | output | 16 | Data driven toward the memory |
| ext_data_oe | output | 1 | Data bus drive enable |
| ext_data_in | input | 16 | Data returned by the memory |
| ext_wait | input | 1 | Wait request from the memory, active high |

## Verification
Two things can happen on the same clock edge: the release of a stretched access and the capture of read data. When wait is honoured, the strobe rises on the edge that follows the first clock in which wait is seen low, and that is also the edge on which read data is taken. The bench drops wait and presents the real read value only in the last strobe-low clock it expects. In every earlier and later clock it puts random values on the data input, so a capture one edge early or late returns the wrong word. A second collision is provoked by changing the timing word, width and wait enable in the clock right after acceptance. The measured phase lengths must still follow the values that were present at acceptance.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   localparam int CNT_W = 5;

   // timing word field positions; sequencing and decode depend on them
   localparam int ACS_LSB  = 13;
   localparam int COS_LSB  = 11;
   localparam int ACC_LSB  = 8;
   localparam int COH_LSB  = 6;
   localparam int CAH_LSB  = 4;
   localparam int PAGE_MSB = 3;

   localparam logic [2:0] WAIT_MIN_CODE = 3'b011;
   localparam logic [1:0] WIDTH_BYTE    = 2'b00;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ASET,
      ST_CSET,
      ST_ACC,
      ST_CHLD,
      ST_AHLD,
      ST_DONE
   } sbc_state_e;

   typedef struct packed {
      logic [CNT_W-1:0] acs;
      logic [CNT_W-1:0] cos;
      logic [CNT_W-1:0] acc;
      logic [CNT_W-1:0] coh;
      logic [CNT_W-1:0] cah;
   } sbc_times_t;

   function automatic logic [CNT_W-1:0] setup_hold_clocks(input logic [1:0] code);
      logic [CNT_W-1:0] r;
      case (code)
         2'b00:   r = CNT_W'(0);
         2'b01:   r = CNT_W'(1);
         2'b10:   r = CNT_W'(2);
         default: r = CNT_W'(4);
      endcase
      return r;
   endfunction

   function automatic logic [CNT_W-1:0] access_clocks(input logic [2:0] code);
      logic [CNT_W-1:0] r;
      if (code <= 3'b011) r = CNT_W'(code) + CNT_W'(1);
      else if (code == 3'b111) r = CNT_W'(14);
      else r = CNT_W'({code[1:0], 1'b0}) + CNT_W'(6);
      return r;
   endfunction

endpackage

// File: rtl/sbc_timing_decode.sv
module sbc_timing_decode
   import sbc_pkg::*;
#(
   parameter int TW = 15
) (
   input  logic [TW-1:0] cfg,
   output sbc_times_t    times
);

   generate
      if (TW != 15) begin : g_bad_tw
         $error("sbc_timing_decode: timing word must be 15 bits");
      end
   endgenerate

   // page fields carry no behaviour in single-data mode
   logic page_unused;
   assign page_unused = ^cfg[PAGE_MSB:0];

   always_comb begin
      times.acs = setup_hold_clocks(cfg[ACS_LSB+1:ACS_LSB]);
      times.cos = setup_hold_clocks(cfg[COS_LSB+1:COS_LSB]);
      times.acc = access_clocks(cfg[ACC_LSB+2:ACC_LSB]);
      times.coh = setup_hold_clocks(cfg[COH_LSB+1:COH_LSB]);
      times.cah = setup_hold_clocks(cfg[CAH_LSB+1:CAH_LSB]);
   end

endmodule

// File: rtl/sbc_addr_window.sv
module sbc_addr_window #(
   parameter int              AW       = 32,
   parameter int              WIN_BITS = 27,
   parameter logic [AW-1:0]   BASE     = 32'h2000_0000
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);

   localparam logic [AW-1:0] LOW_MASK = (AW'(1) << WIN_BITS) - AW'(1);

   generate
      if (WIN_BITS < 1 || WIN_BITS >= AW) begin : g_bad_win
         $error("sbc_addr_window: window size out of range");
      end
      if ((BASE & LOW_MASK) != '0) begin : g_bad_base
         $error("sbc_addr_window: base not aligned to window");
      end
   endgenerate

   assign hit = (addr[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);

   logic low_unused;
   assign low_unused = ^addr[WIN_BITS-1:0];

endmodule

// File: rtl/sbc_phase_seq.sv
module sbc_phase_seq
   import sbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       hit,
   input  sbc_times_t times,
   input  logic       wait_hold,
   output sbc_state_e state,
   output logic       leave_acc
);

   logic [CNT_W-1:0] cnt, cnt_n;
   sbc_state_e       nxt;

   function automatic sbc_state_e follow(input sbc_state_e s, input sbc_times_t t);
      sbc_state_e r;
      case (s)
         ST_IDLE: begin
            if (t.acs != '0) r = ST_ASET;
            else if (t.cos != '0) r = ST_CSET;
            else r = ST_ACC;
         end
         ST_ASET: r = (t.cos != '0) ? ST_CSET : ST_ACC;
         ST_CSET: r = ST_ACC;
         ST_ACC: begin
            if (t.coh != '0) r = ST_CHLD;
            else if (t.cah != '0) r = ST_AHLD;
            else r = ST_DONE;
         end
         ST_CHLD: r = (t.cah != '0) ? ST_AHLD : ST_DONE;
         default: r = ST_DONE;
      endcase
      return r;
   endfunction

   function automatic logic [CNT_W-1:0] phase_len(input sbc_state_e s, input sbc_times_t t);
      logic [CNT_W-1:0] r;
      case (s)
         ST_ASET: r = t.acs;
         ST_CSET: r = t.cos;
         ST_ACC:  r = t.acc;
         ST_CHLD: r = t.coh;
         ST_AHLD: r = t.cah;
         default: r = CNT_W'(1);
      endcase
      return r;
   endfunction

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: begin
            if (start) nxt = hit ? follow(ST_IDLE, times) : ST_DONE;
         end
         ST_ASET, ST_CSET, ST_CHLD, ST_AHLD: begin
            if (cnt == '0) nxt = follow(state, times);
         end
         ST_ACC: begin
            if (cnt == '0 && !wait_hold) nxt = follow(ST_ACC, times);
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      if (nxt != state) cnt_n = phase_len(nxt, times) - CNT_W'(1);
      else if (cnt != '0) cnt_n = cnt - CNT_W'(1);
      else cnt_n = '0;
   end

   assign leave_acc = (state == ST_ACC) && (nxt != ST_ACC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= nxt;
         cnt   <= cnt_n;
      end
   end

   // R8
   wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACC && cnt == '0 && wait_hold) |=> (state == ST_ACC));

   // R4
   acc_exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_ACC && state != ST_ACC) |-> (state inside {ST_CHLD, ST_AHLD, ST_DONE}));

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
   import sbc_pkg::*;
#(
   parameter int            AW           = 32,
   parameter int            DW           = 16,
   parameter int            EXT_AW       = 26,
   parameter int            TW           = 15,
   parameter int            WIN_BITS     = 27,
   parameter logic [31:0]   BANK_BASE    = 32'h2000_0000,
   parameter bit            WAIT_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              rsp_done,
   output logic [DW-1:0]     rsp_rdata,
   input  logic [TW-1:0]     cfg_timing,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_wait_en,
   output logic              ext_cs_n,
   output logic              ext_oe_n,
   output logic              ext_we_n,
   output logic [EXT_AW-1:0] ext_addr,
   output logic [DW-1:0]     ext_data_out,
   output logic              ext_data_oe,
   input  logic [DW-1:0]     ext_data_in,
   input  logic              ext_wait
);

   localparam int HALF = DW / 2;

   generate
      if (DW != 16) begin : g_bad_dw
         $error("sram_bank_ctrl: data bus must be 16 bits");
      end
      if (EXT_AW + 1 > AW) begin : g_bad_ext_aw
         $error("sram_bank_ctrl: external address wider than request address");
      end
   endgenerate

   sbc_state_e       state;
   logic             leave_acc;
   logic             accept;
   logic             hit;
   logic             wait_hold;
   logic             narrow_now, narrow_q;
   logic [TW-1:0]    timing_src;
   logic [TW-1:0]    cfg_q;
   logic [1:0]       width_q;
   logic             wait_en_q;
   logic             write_q;
   logic [EXT_AW-1:0] addr_q;
   logic [DW-1:0]    wdata_q;
   logic [DW-1:0]    rdata_q;
   sbc_times_t       times;

   assign req_ready  = (state == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign timing_src = req_ready ? cfg_timing : cfg_q;
   assign narrow_now = (cfg_width == WIDTH_BYTE);
   assign narrow_q   = (width_q == WIDTH_BYTE);

   sbc_addr_window #(
      .AW       (AW),
      .WIN_BITS (WIN_BITS),
      .BASE     (AW'(BANK_BASE))
   ) u_window (
      .addr (req_addr),
      .hit  (hit)
   );

   sbc_timing_decode #(
      .TW (TW)
   ) u_decode (
      .cfg   (timing_src),
      .times (times)
   );

   generate
      if (WAIT_SUPPORT) begin : g_wait
         assign wait_hold = wait_en_q && ext_wait
                          && (cfg_q[ACC_LSB+2:ACC_LSB] >= WAIT_MIN_CODE);
      end else begin : g_no_wait
         logic wait_unused;
         assign wait_unused = ext_wait ^ wait_en_q;
         assign wait_hold   = 1'b0;
      end
   endgenerate

   sbc_phase_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .hit       (hit),
      .times     (times),
      .wait_hold (wait_hold),
      .state     (state),
      .leave_acc (leave_acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         width_q   <= 2'b01;
         wait_en_q <= 1'b0;
         write_q   <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
      end else if (accept) begin
         cfg_q     <= cfg_timing;
         width_q   <= cfg_width;
         wait_en_q <= cfg_wait_en;
         write_q   <= req_write;
         addr_q    <= narrow_now ? req_addr[EXT_AW-1:0] : req_addr[EXT_AW:1];
         wdata_q   <= narrow_now ? {{HALF{1'b0}}, req_wdata[HALF-1:0]} : req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (leave_acc && !write_q) begin
         rdata_q <= narrow_q ? {{HALF{1'b0}}, ext_data_in[HALF-1:0]} : ext_data_in;
      end
   end

   logic in_ext;
   assign in_ext = state inside {ST_ASET, ST_CSET, ST_ACC, ST_CHLD, ST_AHLD};

   assign ext_cs_n     = !(state inside {ST_CSET, ST_ACC, ST_CHLD});
   assign ext_oe_n     = !((state == ST_ACC) && !write_q);
   assign ext_we_n     = !((state == ST_ACC) && write_q);
   assign ext_addr     = addr_q;
   assign ext_data_out = wdata_q;
   assign ext_data_oe  = write_q && in_ext;
   assign rsp_done     = (state == ST_DONE);
   assign rsp_rdata    = rdata_q;

   // R5
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_oe_n |-> ext_we_n);

   // R4
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_oe_n || !ext_we_n) |-> !ext_cs_n);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R7
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(cfg_q) && $stable(width_q) && $stable(wait_en_q)));

endmodule

// File: tb/sram_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_bank_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [14:0] cfg_timing = '0;
   logic [1:0]  cfg_width = 2'b01;
   logic        cfg_wait_en = 1'b0;
   logic        ext_cs_n, ext_oe_n, ext_we_n, ext_data_oe;
   logic [25:0] ext_addr;
   logic [15:0] ext_data_out;
   logic [15:0] ext_data_in = '0;
   logic        ext_wait = 1'b0;

   int checks = 0;
   int failures = 0;
   logic [15:0] last_rd = '0;

   always #2.5 clk = ~clk;

   sram_bank_ctrl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_done     (rsp_done),
      .rsp_rdata    (rsp_rdata),
      .cfg_timing   (cfg_timing),
      .cfg_width    (cfg_width),
      .cfg_wait_en  (cfg_wait_en),
      .ext_cs_n     (ext_cs_n),
      .ext_oe_n     (ext_oe_n),
      .ext_we_n     (ext_we_n),
      .ext_addr     (ext_addr),
      .ext_data_out (ext_data_out),
      .ext_data_oe  (ext_data_oe),
      .ext_data_in  (ext_data_in),
      .ext_wait     (ext_wait)
   );

   function automatic int sh_clk(input logic [1:0] c);
      case (c)
         2'b00: return 0;
         2'b01: return 1;
         2'b10: return 2;
         default: return 4;
      endcase
   endfunction

   function automatic int acc_clk(input logic [2:0] c);
      case (c)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return 3;
         3'd3: return 4;
         3'd4: return 6;
         3'd5: return 8;
         3'd6: return 10;
         default: return 14;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_txn(input logic wr, input logic [31:0] addr, input logic [15:0] wd,
                          input logic [14:0] tim, input logic [1:0] wid, input logic wen,
                          input int kwait, input logic scramble);
      int a0, a1, a2, a3, a4, guard, bad;
      int e_acs, e_cos, e_acc, e_coh, e_cah;
      logic seen_cs, seen_st, st, hit, narrow, honour;
      logic [15:0] rdv, exp_wd;
      logic [25:0] exp_addr;
      a0 = 0; a1 = 0; a2 = 0; a3 = 0; a4 = 0; bad = 0;
      seen_cs = 1'b0; seen_st = 1'b0;
      hit    = (addr >= 32'h2000_0000) && (addr <= 32'h27FF_FFFF);
      narrow = (wid == 2'b00);
      honour = hit && wen && (tim[10:8] >= 3'b011) && (kwait > 0);
      e_acs  = sh_clk(tim[14:13]);
      e_cos  = sh_clk(tim[12:11]);
      e_acc  = acc_clk(tim[10:8]) + (honour ? kwait : 0);
      e_coh  = sh_clk(tim[7:6]);
      e_cah  = sh_clk(tim[5:4]);
      if (!hit) begin
         e_acs = 0; e_cos = 0; e_acc = 0; e_coh = 0; e_cah = 0;
      end
      rdv      = 16'($urandom);
      exp_addr = narrow ? addr[25:0] : addr[26:1];
      exp_wd   = narrow ? {8'h00, wd[7:0]} : wd;

      @(negedge clk);
      guard = 0;
      while (!req_ready && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      cfg_timing  = tim;
      cfg_width   = wid;
      cfg_wait_en = wen;
      ext_wait    = (kwait > 0);
      req_write   = wr;
      req_addr    = addr;
      req_wdata   = wd;
      req_valid   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 32'($urandom);
      req_wdata = 16'($urandom);
      if (scramble) begin
         cfg_timing  = ~tim;
         cfg_width   = ~wid;
         cfg_wait_en = ~wen;
      end

      guard = 0;
      while (!rsp_done && guard < 300) begin
         st = !ext_oe_n || !ext_we_n;
         if ((wr && !ext_oe_n) || (!wr && !ext_we_n)) bad++;
         if (ext_data_oe !== (wr && hit)) bad++;
         if (st && ext_cs_n) bad++;
         if (!st && ext_cs_n && !seen_cs) a0++;
         else if (!st && !ext_cs_n && !seen_st) begin
            a1++;
            seen_cs = 1'b1;
         end else if (st) begin
            a2++;
            seen_cs = 1'b1;
            if (!seen_st) begin
               // R10 address mapping, R5 write data on the bus
               chk("R10 external address", 32'(ext_addr), 32'(exp_addr));
               if (wr) chk("R5 R10 write data", 32'(ext_data_out), 32'(exp_wd));
            end
            seen_st = 1'b1;
         end else if (!ext_cs_n) a3++;
         else a4++;
         if (kwait > 0 && a2 >= e_acc) ext_wait = 1'b0;
         ext_data_in = (st && a2 == e_acc) ? rdv : 16'($urandom);
         @(negedge clk);
         guard++;
      end

      chk("R7 done reached", 32'(guard < 300), 32'd1);
      chk("R2 R4 address setup clocks", 32'(a0), 32'(e_acs));
      chk("R2 R4 cs setup clocks", 32'(a1), 32'(e_cos));
      chk("R3 R8 strobe clocks", 32'(a2), 32'(e_acc));
      chk("R2 R4 cs hold clocks", 32'(a3), 32'(e_coh));
      chk("R2 R4 address hold clocks", 32'(a4), 32'(e_cah));
      chk("R5 R4 strobe and drive legality", 32'(bad), 32'd0);
      if (!wr && hit) last_rd = narrow ? {8'h00, rdv[7:0]} : rdv;
      // R6 capture edge; R1 unchanged on miss or write
      chk("R6 R10 R1 read data", 32'(rsp_rdata), 32'(last_rd));
      @(negedge clk);
      chk("R7 done single cycle", 32'(rsp_done), 32'd0);
      chk("R7 ready after done", 32'(req_ready), 32'd1);
      ext_wait = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 reset ready", 32'(req_ready), 32'd1);
      chk("R4 reset cs", 32'(ext_cs_n), 32'd1);
      chk("R5 reset strobes", 32'({ext_oe_n, ext_we_n, ext_data_oe}), 32'b110);
      chk("R7 reset done", 32'(rsp_done), 32'd0);
      chk("R6 reset read data", 32'(rsp_rdata), 32'd0);

      // R12 documented words, 16-bit bus
      run_txn(1'b0, 32'h2000_1234, 16'h0000, 15'h5CEC, 2'b01, 1'b0, 0, 1'b0);
      run_txn(1'b1, 32'h2000_4004, 16'hBEEF, 15'h5CEC, 2'b01, 1'b0, 0, 1'b0);
      run_txn(1'b0, 32'h2123_0002, 16'h0000, 15'h3294, 2'b01, 1'b0, 0, 1'b0);
      run_txn(1'b1, 32'h2123_0006, 16'hA5C3, 15'h3294, 2'b01, 1'b0, 0, 1'b0);
      // R4 all phases zero except minimum access; R3 longest word
      run_txn(1'b0, 32'h2000_0000, 16'h0000, 15'h0000, 2'b01, 1'b0, 0, 1'b0);
      run_txn(1'b1, 32'h27FF_FFFE, 16'h1357, 15'h7FF0, 2'b01, 1'b0, 0, 1'b0);
      // R1 window edges outside
      run_txn(1'b0, 32'h1FFF_FFFE, 16'h0000, 15'h5CEC, 2'b01, 1'b0, 0, 1'b0);
      run_txn(1'b1, 32'h2800_0000, 16'h7777, 15'h3294, 2'b01, 1'b0, 0, 1'b0);
      // R8 honoured, below minimum, disabled
      run_txn(1'b0, 32'h2200_0010, 16'h0000, 15'h2300, 2'b01, 1'b1, 3, 1'b0);
      run_txn(1'b0, 32'h2200_0020, 16'h0000, 15'h2200, 2'b01, 1'b1, 3, 1'b0);
      run_txn(1'b1, 32'h2200_0030, 16'h2468, 15'h2440, 2'b01, 1'b0, 2, 1'b0);
      // R10 byte bus and reserved code
      run_txn(1'b0, 32'h2300_0003, 16'h0000, 15'h3294, 2'b00, 1'b0, 0, 1'b0);
      run_txn(1'b1, 32'h2300_0005, 16'hCAFE, 15'h3294, 2'b00, 1'b0, 0, 1'b0);
      run_txn(1'b0, 32'h2300_0008, 16'h0000, 15'h3294, 2'b10, 1'b0, 0, 1'b0);
      // R11 page fields set
      run_txn(1'b0, 32'h2400_0100, 16'h0000, 15'h5CEF, 2'b01, 1'b0, 0, 1'b0);
      // R9 configuration changed right after acceptance, with stretch
      run_txn(1'b0, 32'h2500_0040, 16'h0000, 15'h5CEC, 2'b01, 1'b1, 2, 1'b1);
      run_txn(1'b1, 32'h2500_0044, 16'h9191, 15'h3294, 2'b00, 1'b0, 0, 1'b1);

      for (int i = 0; i < 60; i++) begin
         logic [31:0] a;
         int kw;
         a  = ($urandom % 4 != 0) ? (32'h2000_0000 | ($urandom & 32'h07FF_FFFF)) : $urandom;
         kw = ($urandom % 3 == 0) ? int'(1 + $urandom % 4) : 0;
         run_txn(1'($urandom), a, 16'($urandom), 15'($urandom), 2'($urandom),
                 1'($urandom), kw, ($urandom % 8 == 0));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule